// File: doc/BRIEF.md
# Non-volatile array word-program and page-erase sequencer

This block drives the strobes of an embedded non-volatile memory array through the two write-type operations: storing one word and erasing one row (page). A host issues a command in two writes. The first write carries an operation code and arms the block. The second write carries the address (and, for a program, the data word) and starts the operation. While the block is idle or armed, the address and data holding register follows every argument write. It closes when the operation starts and holds its value until the block is idle again.

Once started, the sequencer raises a busy flag and steps the row strobe, the mode strobe (program or erase), the high-voltage store strobe and the column strobe in strictly nested order. Every gap between two edges is a minimum time given in nanoseconds. Each one is turned into a clock-cycle count from a clock-frequency parameter, rounding up. Page erase never touches the column strobe or the read-path strobes. A host write that arrives during an operation is dropped and reported. The block also keeps, for each row, the total time the store strobe has been high during programming. It raises a sticky fault when that total goes beyond a limit before the row is erased.

States: `ST_IDLE`, `ST_ARMED`, `ST_MODE_SU`, `ST_PG_SU`, `ST_ADDR_SU`, `ST_PULSE`, `ST_PG_HOLD`, `ST_ER_PULSE`, `ST_NV_HOLD`, `ST_RECOVER`.

Transitions:
- IDLE→ARMED on a valid operation write.
- ARMED→ARMED on a further valid operation write, which replaces the operation.
- ARMED→IDLE on an invalid operation write.
- ARMED→MODE_SU on an argument write.
- MODE_SU→PG_SU (program) or →ER_PULSE (erase).
- PG_SU→ADDR_SU→PULSE→PG_HOLD→NV_HOLD.
- ER_PULSE→NV_HOLD.
- NV_HOLD→RECOVER→IDLE.

Each timed state lasts exactly its cycle count.

Top module: `nvm_seq`

## Requirements
- R1: After reset, busy, cmd_err, hv_fault and every array strobe are 0.
- R2: A write with hw_sel=0 and hw_op 2'b01 (program) or 2'b10 (erase) arms the block, and a later write of that kind replaces the armed operation. hw_op 2'b00 or 2'b11 disarms it. A write with hw_sel=1 starts the armed operation, and busy is 1 from the next cycle. A hw_sel=1 write while not armed starts nothing.
- R3: A program raises the row strobe and the program mode strobe for C_NVS cycles, then the store strobe. The column strobe rises C_PGS+C_ADS cycles after the store strobe and stays high for C_PROG cycles.
- R4: After the column pulse, the program mode strobe stays high for max(C_ADH,C_PGH) cycles. The store strobe outlasts the mode strobe by C_NVH cycles. This is followed by C_RCV cycles with every strobe low before busy falls.
- R5: Row address (addr[7:5]), column address (addr[4:0]) and data driven to the array equal the values of the starting argument write, and they are stable for the whole busy period.
- R6: An erase keeps the column strobe low throughout. It runs erase mode with the row strobe for C_NVS cycles, then the store strobe with erase mode for C_ERASE cycles, then the store strobe alone for C_NVH cycles, then C_RCV cycles of recovery.
- R7: Every interval count C_x is ceil(T_x_NS × CLK_MHZ / 1000), with a minimum of 1.
- R8: busy lasts exactly as many cycles as the timed states of the operation add up to, and it falls only in the cycle the block returns to idle.
- R9: Any host write while busy is ignored: the running operation, its address and its length are unchanged. cmd_err pulses high in the cycle after each such write.
- R10: Store-strobe cycles during programming add up per row. Starting an erase of a row clears that row's total. hv_fault goes to 1 once any total exceeds C_HVMAX, and stays 1 until reset.
- R11: Program mode and erase mode are never high together. The column strobe is high only while the program mode, store and row strobes are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_en | input | 1 | Host write strobe |
| hw_sel | input | 1 | 0 = operation write, 1 = argument write |
| hw_op | input | 2 | Operation code (01 program, 10 erase) |
| hw_addr | input | ROW_W+COL_W | Row and column address |
| hw_data | input | DW | Word to program |
| busy | output | 1 | Operation in progress |
| cmd_err | output | 1 | Write rejected while busy |
| hv_fault | output | 1 | Sticky cumulative high-voltage fault |
| arr_row_en | output | 1 | Row strobe |
| arr_col_en | output | 1 | Column strobe |
| arr_sense | output | 1 | Read sense strobe, held low |
| arr_outen | output | 1 | Read output enable, held low |
| arr_bank_sel | output | 1 | Auxiliary bank select, held low |
| arr_pgm_mode | output | 1 | Program mode strobe |
| arr_ers_mode | output | 1 | Erase mode strobe |
| arr_hv_store | output | 1 | High-voltage store strobe |
| arr_row_addr | output | ROW_W | Row address to array |
| arr_col_addr | output | COL_W | Column address to array |
| arr_wdata | output | DW | Data to array |

## Verification
The bench measures how long each strobe overlap lasts: mode alone, mode with store, store alone, and the column pulse. If one interval were swapped or miscounted by a cycle, one of these counts would be off. Writes during busy are aimed at the middle of a program. A design that still accepted them would lengthen busy or move the row address. A design that did not reject them would miss the cmd_err pulses. The host protocol is probed with an argument write given without arming, an invalid code, and re-arming to a different operation. A loose decoder would start the wrong operation or start one with no operation armed. A program→erase→program pattern on one row and a program→program pattern on another check the high-voltage total. A monitor that never cleared would fault on the first, and one that never added up would stay silent on the second.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ARMED,
        ST_MODE_SU,
        ST_PG_SU,
        ST_ADDR_SU,
        ST_PULSE,
        ST_PG_HOLD,
        ST_ER_PULSE,
        ST_NV_HOLD,
        ST_RECOVER
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PGM  = 2'b01,
        OP_ERS  = 2'b10,
        OP_RSV  = 2'b11
    } seq_op_e;

    // Minimum time in ns -> clock cycles, rounded up, never below one.
    function automatic int unsigned ns_to_cyc(longint unsigned ns, longint unsigned mhz);
        longint unsigned c;
        c = (ns * mhz + 64'd999) / 64'd1000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nvm_seq_timer.sv
module nvm_seq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/nvm_seq_latch.sv
module nvm_seq_latch #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (ld) begin
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end
endmodule

// File: rtl/nvm_seq_hvmon.sv
module nvm_seq_hvmon #(
    parameter int          ROW_W = 3,
    parameter int unsigned LIMIT = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hv_on,
    input  logic [ROW_W-1:0] hv_row,
    input  logic             clr,
    input  logic [ROW_W-1:0] clr_row,
    output logic             fault
);
    localparam int ROWS = 1 << ROW_W;
    localparam int HCW  = $clog2(LIMIT + 2);

    logic [ROWS-1:0] over;
    logic            fault_q;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [HCW-1:0] acc_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                acc_q <= '0;
            else if (clr && clr_row == ROW_W'(r))
                acc_q <= '0;
            else if (hv_on && hv_row == ROW_W'(r) && acc_q <= HCW'(LIMIT))
                acc_q <= acc_q + HCW'(1);
        end
        assign over[r] = (acc_q > HCW'(LIMIT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fault_q <= 1'b0;
        else if (|over)
            fault_q <= 1'b1;
    end

    assign fault = fault_q;
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
    import nvm_seq_pkg::*;
#(
    parameter int          ROW_W       = 3,
    parameter int          COL_W       = 5,
    parameter int          DW          = 32,
    parameter int unsigned CLK_MHZ     = 25,
    parameter int unsigned T_NVS_NS    = 5000,
    parameter int unsigned T_PGS_NS    = 10000,
    parameter int unsigned T_ADS_NS    = 20,
    parameter int unsigned T_PROG_NS   = 30000,
    parameter int unsigned T_ADH_NS    = 20,
    parameter int unsigned T_PGH_NS    = 20000,
    parameter int unsigned T_NVH_NS    = 5000,
    parameter int unsigned T_RCV_NS    = 1000,
    parameter int unsigned T_ERASE_NS  = 20000000,
    parameter int unsigned T_HVMAX_NS  = 4000000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hw_en,
    input  logic                   hw_sel,
    input  logic [1:0]             hw_op,
    input  logic [ROW_W+COL_W-1:0] hw_addr,
    input  logic [DW-1:0]          hw_data,
    output logic                   busy,
    output logic                   cmd_err,
    output logic                   hv_fault,
    output logic                   arr_row_en,
    output logic                   arr_col_en,
    output logic                   arr_sense,
    output logic                   arr_outen,
    output logic                   arr_bank_sel,
    output logic                   arr_pgm_mode,
    output logic                   arr_ers_mode,
    output logic                   arr_hv_store,
    output logic [ROW_W-1:0]       arr_row_addr,
    output logic [COL_W-1:0]       arr_col_addr,
    output logic [DW-1:0]          arr_wdata
);
    localparam int          AW      = ROW_W + COL_W;
    localparam int unsigned C_NVS   = ns_to_cyc(T_NVS_NS, CLK_MHZ);
    localparam int unsigned C_PGS   = ns_to_cyc(T_PGS_NS, CLK_MHZ);
    localparam int unsigned C_ADS   = ns_to_cyc(T_ADS_NS, CLK_MHZ);
    localparam int unsigned C_PROG  = ns_to_cyc(T_PROG_NS, CLK_MHZ);
    localparam int unsigned C_PGH   = umax(ns_to_cyc(T_ADH_NS, CLK_MHZ),
                                           ns_to_cyc(T_PGH_NS, CLK_MHZ));
    localparam int unsigned C_NVH   = ns_to_cyc(T_NVH_NS, CLK_MHZ);
    localparam int unsigned C_RCV   = ns_to_cyc(T_RCV_NS, CLK_MHZ);
    localparam int unsigned C_ERASE = ns_to_cyc(T_ERASE_NS, CLK_MHZ);
    localparam int unsigned C_HVMAX = ns_to_cyc(T_HVMAX_NS, CLK_MHZ);
    localparam int unsigned C_MAX   = umax(umax(umax(C_NVS, C_PGS), umax(C_ADS, C_PROG)),
                                           umax(umax(C_PGH, C_NVH), umax(C_RCV, C_ERASE)));
    localparam int          CW      = $clog2(C_MAX + 1);

    seq_state_e    state_q, state_d;
    seq_op_e       op_q;
    logic          tmr_done;
    logic [CW-1:0] tmr_val;
    logic          host_open;
    logic          op_wr_ok;
    logic          start;
    logic          err_q;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_data;

    assign host_open = (state_q == ST_IDLE) || (state_q == ST_ARMED);
    assign op_wr_ok  = (hw_op == OP_PGM) || (hw_op == OP_ERS);
    assign start     = (state_q == ST_ARMED) && hw_en && hw_sel;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (hw_en && !hw_sel && op_wr_ok) state_d = ST_ARMED;
            ST_ARMED:    if (hw_en) begin
                             if (hw_sel)        state_d = ST_MODE_SU;
                             else if (!op_wr_ok) state_d = ST_IDLE;
                         end
            ST_MODE_SU:  if (tmr_done) state_d = (op_q == OP_PGM) ? ST_PG_SU : ST_ER_PULSE;
            ST_PG_SU:    if (tmr_done) state_d = ST_ADDR_SU;
            ST_ADDR_SU:  if (tmr_done) state_d = ST_PULSE;
            ST_PULSE:    if (tmr_done) state_d = ST_PG_HOLD;
            ST_PG_HOLD:  if (tmr_done) state_d = ST_NV_HOLD;
            ST_ER_PULSE: if (tmr_done) state_d = ST_NV_HOLD;
            ST_NV_HOLD:  if (tmr_done) state_d = ST_RECOVER;
            ST_RECOVER:  if (tmr_done) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Interval length for the state being entered (count minus one).
    always_comb begin
        unique case (state_d)
            ST_MODE_SU:  tmr_val = CW'(C_NVS - 1);
            ST_PG_SU:    tmr_val = CW'(C_PGS - 1);
            ST_ADDR_SU:  tmr_val = CW'(C_ADS - 1);
            ST_PULSE:    tmr_val = CW'(C_PROG - 1);
            ST_PG_HOLD:  tmr_val = CW'(C_PGH - 1);
            ST_ER_PULSE: tmr_val = CW'(C_ERASE - 1);
            ST_NV_HOLD:  tmr_val = CW'(C_NVH - 1);
            ST_RECOVER:  tmr_val = CW'(C_RCV - 1);
            default:     tmr_val = '0;
        endcase
    end

    // State register, operation register and reject flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_NONE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (host_open && hw_en && !hw_sel)
                op_q <= seq_op_e'(hw_op);
            err_q <= hw_en && !host_open;
        end
    end

    nvm_seq_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_d != state_q),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    nvm_seq_latch #(.AW(AW), .DW(DW)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (host_open && hw_en && hw_sel),
        .addr_in (hw_addr),
        .data_in (hw_data),
        .addr_q  (lat_addr),
        .data_q  (lat_data)
    );

    nvm_seq_hvmon #(.ROW_W(ROW_W), .LIMIT(C_HVMAX)) u_hv (
        .clk     (clk),
        .rst_n   (rst_n),
        .hv_on   (arr_hv_store && (op_q == OP_PGM)),
        .hv_row  (lat_addr[AW-1:COL_W]),
        .clr     (start && (op_q == OP_ERS)),
        .clr_row (hw_addr[AW-1:COL_W]),
        .fault   (hv_fault)
    );

    // Strobe decode from the state register.
    always_comb begin
        arr_row_en   = 1'b0;
        arr_col_en   = 1'b0;
        arr_pgm_mode = 1'b0;
        arr_ers_mode = 1'b0;
        arr_hv_store = 1'b0;
        busy         = 1'b1;
        unique case (state_q)
            ST_IDLE, ST_ARMED: busy = 1'b0;
            ST_MODE_SU: begin
                arr_row_en   = 1'b1;
                arr_pgm_mode = (op_q == OP_PGM);
                arr_ers_mode = (op_q == OP_ERS);
            end
            ST_PG_SU, ST_ADDR_SU, ST_PG_HOLD: begin
                arr_row_en   = 1'b1;
                arr_pgm_mode = 1'b1;
                arr_hv_store = 1'b1;
            end
            ST_PULSE: begin
                arr_row_en   = 1'b1;
                arr_pgm_mode = 1'b1;
                arr_hv_store = 1'b1;
                arr_col_en   = 1'b1;
            end
            ST_ER_PULSE: begin
                arr_row_en   = 1'b1;
                arr_ers_mode = 1'b1;
                arr_hv_store = 1'b1;
            end
            ST_NV_HOLD: begin
                arr_row_en   = 1'b1;
                arr_hv_store = 1'b1;
            end
            ST_RECOVER: ;
            default: busy = 1'b0;
        endcase
    end

    assign cmd_err      = err_q;
    assign arr_sense    = 1'b0;
    assign arr_outen    = 1'b0;
    assign arr_bank_sel = 1'b0;
    assign arr_row_addr = lat_addr[AW-1:COL_W];
    assign arr_col_addr = lat_addr[COL_W-1:0];
    assign arr_wdata    = lat_data;
endmodule

// File: rtl/nvm_seq_chk.sv
module nvm_seq_chk #(
    parameter int ROW_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hw_en,
    input logic             busy,
    input logic             cmd_err,
    input logic             hv_fault,
    input logic             row_en,
    input logic             col_en,
    input logic             pgm,
    input logic             ers,
    input logic             hv,
    input logic [ROW_W-1:0] row_addr
);
    a_r11_col_window: assert property (@(posedge clk) disable iff (!rst_n)
        col_en |-> (pgm && hv && row_en));

    a_r11_mode_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(pgm && ers));

    a_r3_store_after_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hv) |-> $past(pgm || ers));

    a_r4_store_outlasts_mode: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pgm) || $fell(ers)) |-> hv);

    a_r4_modes_low_at_store_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hv) |-> (!pgm && !ers));

    a_r6_erase_no_column: assert property (@(posedge clk) disable iff (!rst_n)
        ers |-> !col_en);

    a_r5_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(row_addr));

    a_r8_idle_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!hv && !pgm && !ers && !row_en));

    a_r9_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_en && busy) |=> cmd_err);

    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hv_fault) |-> hv_fault);
endmodule

bind nvm_seq nvm_seq_chk #(.ROW_W(ROW_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_en    (hw_en),
    .busy     (busy),
    .cmd_err  (cmd_err),
    .hv_fault (hv_fault),
    .row_en   (arr_row_en),
    .col_en   (arr_col_en),
    .pgm      (arr_pgm_mode),
    .ers      (arr_ers_mode),
    .hv       (arr_hv_store),
    .row_addr (arr_row_addr)
);

// File: tb/sim_nvm_seq.sv
module sim_nvm_seq;
    // Small frequency so intervals stay short; the bench computes counts itself (R7).
    localparam int unsigned MHZ = 1;
    localparam int unsigned NVS = 5, PGS = 10, ADS = 1, PRG = 30, PGH = 20;
    localparam int unsigned NVH = 5, RCV = 1, ERS = 40, HVMAX = 100;
    localparam int PGM_BUSY = NVS + PGS + ADS + PRG + PGH + NVH + RCV;
    localparam int ERS_BUSY = NVS + ERS + NVH + RCV;

    // Vector: {op[1:0], addr[7:0], data[31:0]}
    localparam logic [41:0] VEC [0:3] = '{
        {2'b01, 8'b001_00100, 32'hA5A5_0F0F},
        {2'b10, 8'b001_00000, 32'h0000_0000},
        {2'b01, 8'b111_11111, 32'hFFFF_FFFF},
        {2'b10, 8'b000_10101, 32'h1234_5678}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_en = 1'b0, hw_sel = 1'b0;
    logic [1:0]  hw_op = 2'b00;
    logic [7:0]  hw_addr = '0;
    logic [31:0] hw_data = '0;
    logic        busy, cmd_err, hv_fault;
    logic        row_en, col_en, sense, outen, bsel, pgm, ers, hv;
    logic [2:0]  row_addr;
    logic [4:0]  col_addr;
    logic [31:0] wdata;

    int nchk = 0, nfail = 0;
    int c_busy, c_row, c_mode_only, c_mode_hv, c_col, c_hv_only, c_err, c_rdq, c_mism;
    logic [7:0]  exp_addr;
    logic [31:0] exp_data;

    always #5ns clk = ~clk;

    nvm_seq #(
        .CLK_MHZ(MHZ), .T_NVS_NS(5000), .T_PGS_NS(10000), .T_ADS_NS(20),
        .T_PROG_NS(30000), .T_ADH_NS(20), .T_PGH_NS(20000), .T_NVH_NS(5000),
        .T_RCV_NS(1000), .T_ERASE_NS(40000), .T_HVMAX_NS(100000)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_sel(hw_sel), .hw_op(hw_op),
        .hw_addr(hw_addr), .hw_data(hw_data), .busy(busy), .cmd_err(cmd_err),
        .hv_fault(hv_fault), .arr_row_en(row_en), .arr_col_en(col_en),
        .arr_sense(sense), .arr_outen(outen), .arr_bank_sel(bsel),
        .arr_pgm_mode(pgm), .arr_ers_mode(ers), .arr_hv_store(hv),
        .arr_row_addr(row_addr), .arr_col_addr(col_addr), .arr_wdata(wdata)
    );

    always @(negedge clk) begin
        if (busy) c_busy++;
        if (row_en) c_row++;
        if ((pgm || ers) && !hv) c_mode_only++;
        if ((pgm || ers) && hv && !col_en) c_mode_hv++;
        if (col_en) c_col++;
        if (hv && !pgm && !ers) c_hv_only++;
        if (cmd_err) c_err++;
        if (sense || outen || bsel) c_rdq++;
        if (busy && ({row_addr, col_addr} != exp_addr || wdata != exp_data)) c_mism++;
    end

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_counts();
        c_busy = 0; c_row = 0; c_mode_only = 0; c_mode_hv = 0; c_col = 0;
        c_hv_only = 0; c_err = 0; c_rdq = 0; c_mism = 0;
    endtask

    task automatic wr(input logic sel, input logic [1:0] op, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        hw_en = 1'b1; hw_sel = sel; hw_op = op; hw_addr = a; hw_data = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [7:0] a, input logic [31:0] d);
        exp_addr = a; exp_data = d;
        clr_counts();
        wr(1'b0, op, 8'h00, 32'h0);
        wr(1'b1, 2'b00, a, d);
        wait_idle();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        #1ms;
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        clr_counts();
        exp_addr = '0; exp_data = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 busy", int'(busy), 0);
        check("R1 strobes", int'({row_en, col_en, pgm, ers, hv}), 0);
        check("R1 flags", int'({cmd_err, hv_fault}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table: R2 R3 R4 R5 R6 R7 R8 R11
        for (int i = 0; i < 4; i++) begin
            logic [1:0] op;
            op = VEC[i][41:40];
            run_cmd(op, VEC[i][39:32], VEC[i][31:0]);
            check("R5 addr/data", c_mism, 0);
            check("R6 read strobes low", c_rdq, 0);
            if (op == 2'b01) begin
                check("R8 program busy", c_busy, PGM_BUSY);
                check("R3 mode before store", c_mode_only, NVS);
                check("R3 column pulse", c_col, PRG);
                check("R4 mode with store", c_mode_hv, PGS + ADS + PGH);
                check("R4 store after mode", c_hv_only, NVH);
                check("R4 row strobe", c_row, PGM_BUSY - RCV);
            end else begin
                check("R8 erase busy", c_busy, ERS_BUSY);
                check("R6 mode before store", c_mode_only, NVS);
                check("R6 erase pulse", c_mode_hv, ERS);
                check("R6 no column", c_col, 0);
                check("R6 store after mode", c_hv_only, NVH);
                check("R6 row strobe", c_row, ERS_BUSY - RCV);
            end
        end

        // R9: writes during a program are rejected
        exp_addr = 8'b101_00011; exp_data = 32'hCAFE_0001;
        clr_counts();
        wr(1'b0, 2'b01, 8'h00, 32'h0);
        wr(1'b1, 2'b00, exp_addr, exp_data);
        repeat (15) @(negedge clk);
        wr(1'b0, 2'b10, 8'h00, 32'h0);
        wr(1'b1, 2'b00, 8'b010_01010, 32'hDEAD_BEEF);
        wait_idle();
        check("R9 busy unchanged", c_busy, PGM_BUSY);
        check("R9 latch kept", c_mism, 0);
        check("R9 cmd_err pulses", c_err, 2);
        clr_counts();
        repeat (20) @(negedge clk);
        check("R9 no late start", c_busy, 0);

        // R2: argument write while not armed
        clr_counts();
        wr(1'b1, 2'b00, 8'h11, 32'h1);
        repeat (10) @(negedge clk);
        check("R2 unarmed no start", c_busy, 0);
        // R2: invalid code disarms
        wr(1'b0, 2'b11, 8'h00, 32'h0);
        wr(1'b1, 2'b00, 8'h22, 32'h2);
        repeat (10) @(negedge clk);
        check("R2 invalid op no start", c_busy, 0);
        // R2: re-arm to erase
        exp_addr = 8'b110_00000; exp_data = 32'h0;
        clr_counts();
        wr(1'b0, 2'b01, 8'h00, 32'h0);
        wr(1'b0, 2'b10, 8'h00, 32'h0);
        wr(1'b1, 2'b00, exp_addr, exp_data);
        wait_idle();
        check("R2 rearm runs erase", c_busy, ERS_BUSY);
        check("R2 rearm no column", c_col, 0);

        // R10: program/erase/program on one row stays below the limit
        run_cmd(2'b01, 8'b011_00001, 32'h1);
        run_cmd(2'b10, 8'b011_00000, 32'h0);
        run_cmd(2'b01, 8'b011_00010, 32'h2);
        check("R10 erase clears total", int'(hv_fault), 0);
        // R10: two programs on one row exceed it
        run_cmd(2'b01, 8'b010_00001, 32'h3);
        check("R10 one program below limit", int'(hv_fault), 0);
        run_cmd(2'b01, 8'b010_00010, 32'h4);
        check("R10 fault raised", int'(hv_fault), 1);
        run_cmd(2'b10, 8'b010_00000, 32'h0);
        check("R10 fault sticky", int'(hv_fault), 1);

        // R1: reset clears the fault
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 fault cleared", int'(hv_fault), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        summary();
    end
endmodule